// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block rewrites request addresses for a set of source ports. Each port owns a small bank of translation entries. An entry names a source window, which is a naturally aligned power-of-two region, and a translated base. It also carries a destination identifier that steers a hit toward a downstream target. A lookup presents a port number and an address. The enabled entries of that port are compared against the address. On a hit, the bits above the window offset are replaced by the translated base. The offset bits pass through unchanged, and the entry's destination is returned. A special size code turns an entry into a pass-through window that covers the whole address space.

Software programs the entries through a 32-bit register port. Each 64-bit register takes two writes: the low word first, then the high word. The second write makes the whole value live in one step. Every register reads back the value that is currently live. Lookups are pipelined with one register stage, so a response appears on the cycle after its request.

Top module: `atu_top`

## Requirements
- R1: After synchronous reset, every entry is disabled, every register reads zero, and rsp_valid and rsp_hit are low.
- R2: The write and read address is {port[2:0], table[1:0], reg[1:0], half}. The reg values are 0 = source, 1 = translated base, 2 = destination, and 3 = none. half is 0 for bits 31:0 and 1 for bits 63:32. Reads return the live register contents. Reg 3, the upper half of reg 2, and ports 6 and 7 read zero.
- R3: A low-half write to reg 0 or reg 1 only stages the word. Readback and lookups stay unchanged until the matching high-half write, which commits {high, staged low} at once.
- R4: In a source register, bit 0 enables the entry, bits 6:1 hold the size code s, and bits 63:12 hold the base; bits 11:7 are ignored. The window spans 2^(s+1) bytes. An address matches when its bits above the offset equal the base's bits above the offset.
- R5: On a hit, rsp_addr takes the translated base (bits 63:12 of reg 1) above the offset and the request address inside the offset.
- R6: Size code 63 is transparent. The entry matches every address and returns it unchanged.
- R7: Reg 2 bits 2:0 hold the destination code and all other bits read zero. Codes 2 and 3 are stored like any other code. On a hit, rsp_dest carries the code and rsp_table carries the entry index.
- R8: When several enabled entries of one port match, the lowest table index wins.
- R9: On a miss, rsp_hit, rsp_dest and rsp_table are zero and rsp_addr equals the request address. A miss results when only other ports' entries match, when the matching entry is disabled, and for port codes 6 and 7.
- R10: Committing zero to a source register disables that entry.
- R11: A response appears exactly one cycle after each request. A lookup in the same cycle as a commit sees the configuration from before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 8 | Write address {port, table, reg, half} |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 8 | Read address, same layout |
| cfg_rdata | output | 32 | Combinational readback |
| req_valid | input | 1 | Lookup request |
| req_port | input | 3 | Source port of the request |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_hit | output | 1 | An enabled entry matched |
| rsp_addr | output | 64 | Translated or unchanged address |
| rsp_dest | output | 3 | Destination code of the hit, else zero |
| rsp_table | output | 2 | Index of the winning entry, else zero |

## Verification
A register commit and a lookup can fall in the same cycle. The bench drives a high-half write that zeroes the winning entry's source register and a lookup into that window on the same clock edge. The response must still carry the old translation. A second lookup straight after must fall through to the next-priority entry.

// File: rtl/atu_pkg.sv
package atu_pkg;
    localparam int ATU_ADDR_W   = 64;
    localparam int ATU_DATA_W   = 32;
    localparam int ATU_SIZE_W   = 6;
    localparam int ATU_DEST_W   = 3;
    localparam int ATU_BASE_LSB = 12;
    localparam int ATU_TBL_W    = 2;

    localparam logic [ATU_ADDR_W-1:0] ATU_BASE_MASK =
        ~((ATU_ADDR_W'(1) << ATU_BASE_LSB) - ATU_ADDR_W'(1));

    typedef enum logic [1:0] {
        REG_SRC  = 2'd0,
        REG_TRSL = 2'd1,
        REG_DEST = 2'd2,
        REG_NONE = 2'd3
    } atu_reg_e;

    typedef struct packed {
        logic [ATU_ADDR_W-1:0] src;
        logic [ATU_ADDR_W-1:0] trsl;
        logic [ATU_DEST_W-1:0] dest;
    } atu_entry_t;

    typedef struct packed {
        logic                  hit;
        logic [ATU_ADDR_W-1:0] addr;
        logic [ATU_DEST_W-1:0] dest;
        logic [ATU_TBL_W-1:0]  tbl;
    } atu_result_t;

    function automatic logic entry_on(input logic [ATU_ADDR_W-1:0] src);
        return src[0];
    endfunction

    function automatic logic [ATU_SIZE_W-1:0] entry_size(input logic [ATU_ADDR_W-1:0] src);
        return src[ATU_SIZE_W:1];
    endfunction

    // bits kept from the request: span is 2^(code+1)
    function automatic logic [ATU_ADDR_W-1:0] offset_mask(input logic [ATU_SIZE_W-1:0] sz);
        int e;
        e = int'(sz) + 1;
        if (e >= ATU_ADDR_W) return '1;
        return (ATU_ADDR_W'(1) << e) - ATU_ADDR_W'(1);
    endfunction
endpackage

// File: rtl/atu_regfile.sv
module atu_regfile
    import atu_pkg::*;
#(
    parameter int NUM_PORTS  = 6,
    parameter int NUM_TABLES = 4,
    parameter int PORT_W     = 3,
    parameter int CFG_AW     = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [CFG_AW-1:0]     waddr,
    input  logic [ATU_DATA_W-1:0] wdata,
    input  logic [CFG_AW-1:0]     raddr,
    output logic [ATU_DATA_W-1:0] rdata,
    output atu_entry_t            entries [NUM_PORTS*NUM_TABLES]
);
    localparam int N_ENT = NUM_PORTS * NUM_TABLES;

    atu_entry_t                ent_q [N_ENT];
    logic [ATU_DATA_W-1:0]     stage_q;

    logic                      w_half;
    atu_reg_e                  w_reg;
    logic [ATU_TBL_W-1:0]      w_tbl;
    logic [PORT_W-1:0]         w_port;
    logic                      w_ok;
    int                        w_idx;

    assign w_half = waddr[0];
    assign w_reg  = atu_reg_e'(waddr[2:1]);
    assign w_tbl  = waddr[3 +: ATU_TBL_W];
    assign w_port = waddr[3+ATU_TBL_W +: PORT_W];
    assign w_ok   = int'(w_port) < NUM_PORTS;
    assign w_idx  = int'(w_port) * NUM_TABLES + int'(w_tbl);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
            stage_q <= '0;
        end else if (we) begin
            if (!w_half && (w_reg == REG_SRC || w_reg == REG_TRSL))
                stage_q <= wdata;
            if (w_ok) begin
                case (w_reg)
                    REG_SRC:  if (w_half) ent_q[w_idx].src  <= {wdata, stage_q};
                    REG_TRSL: if (w_half) ent_q[w_idx].trsl <= {wdata, stage_q};
                    REG_DEST: if (!w_half) ent_q[w_idx].dest <= wdata[ATU_DEST_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    logic                  r_half;
    atu_reg_e              r_reg;
    logic [ATU_TBL_W-1:0]  r_tbl;
    logic [PORT_W-1:0]     r_port;
    atu_entry_t            r_ent;

    assign r_half = raddr[0];
    assign r_reg  = atu_reg_e'(raddr[2:1]);
    assign r_tbl  = raddr[3 +: ATU_TBL_W];
    assign r_port = raddr[3+ATU_TBL_W +: PORT_W];

    always_comb begin
        r_ent = '0;
        if (int'(r_port) < NUM_PORTS)
            r_ent = ent_q[int'(r_port) * NUM_TABLES + int'(r_tbl)];
        case (r_reg)
            REG_SRC:  rdata = r_half ? r_ent.src[63:32]  : r_ent.src[31:0];
            REG_TRSL: rdata = r_half ? r_ent.trsl[63:32] : r_ent.trsl[31:0];
            REG_DEST: rdata = r_half ? '0 : ATU_DATA_W'(r_ent.dest);
            default:  rdata = '0;
        endcase
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_out
        assign entries[g] = ent_q[g];
    end
endmodule

// File: rtl/atu_port_match.sv
module atu_port_match
    import atu_pkg::*;
#(
    parameter int NUM_TABLES = 4
) (
    input  atu_entry_t            ent [NUM_TABLES],
    input  logic [ATU_ADDR_W-1:0] addr,
    output atu_result_t           res
);
    logic [NUM_TABLES-1:0]  hit_vec;
    logic [ATU_ADDR_W-1:0]  xlat [NUM_TABLES];

    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
        logic [ATU_ADDR_W-1:0] keep;
        logic [ATU_ADDR_W-1:0] sbase;
        logic [ATU_ADDR_W-1:0] tbase;
        assign keep       = offset_mask(entry_size(ent[t].src));
        assign sbase      = ent[t].src  & ATU_BASE_MASK;
        assign tbase      = ent[t].trsl & ATU_BASE_MASK;
        assign hit_vec[t] = entry_on(ent[t].src) && (((addr ^ sbase) & ~keep) == '0);
        assign xlat[t]    = (tbase & ~keep) | (addr & keep);
    end

    // scan downward so the lowest index is the last to assign
    always_comb begin
        res.hit  = 1'b0;
        res.addr = addr;
        res.dest = '0;
        res.tbl  = '0;
        for (int t = NUM_TABLES - 1; t >= 0; t--) begin
            if (hit_vec[t]) begin
                res.hit  = 1'b1;
                res.addr = xlat[t];
                res.dest = ent[t].dest;
                res.tbl  = ATU_TBL_W'(t);
            end
        end
    end
endmodule

// File: rtl/atu_top.sv
module atu_top
    import atu_pkg::*;
#(
    parameter int NUM_PORTS  = 6,
    parameter int NUM_TABLES = 4,
    parameter int PORT_W     = 3,
    parameter int CFG_AW     = PORT_W + ATU_TBL_W + 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_waddr,
    input  logic [ATU_DATA_W-1:0] cfg_wdata,
    input  logic [CFG_AW-1:0]     cfg_raddr,
    output logic [ATU_DATA_W-1:0] cfg_rdata,
    input  logic                  req_valid,
    input  logic [PORT_W-1:0]     req_port,
    input  logic [ATU_ADDR_W-1:0] req_addr,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [ATU_ADDR_W-1:0] rsp_addr,
    output logic [ATU_DEST_W-1:0] rsp_dest,
    output logic [ATU_TBL_W-1:0]  rsp_table
);
    atu_entry_t  entries [NUM_PORTS*NUM_TABLES];
    atu_result_t port_res [NUM_PORTS];
    atu_result_t sel_res;

    atu_regfile #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_TABLES(NUM_TABLES),
        .PORT_W    (PORT_W),
        .CFG_AW    (CFG_AW)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .waddr  (cfg_waddr),
        .wdata  (cfg_wdata),
        .raddr  (cfg_raddr),
        .rdata  (cfg_rdata),
        .entries(entries)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        atu_entry_t pent [NUM_TABLES];
        for (genvar t = 0; t < NUM_TABLES; t++) begin : g_slice
            assign pent[t] = entries[p*NUM_TABLES + t];
        end
        atu_port_match #(.NUM_TABLES(NUM_TABLES)) u_match (
            .ent (pent),
            .addr(req_addr),
            .res (port_res[p])
        );
    end

    always_comb begin
        sel_res      = '0;
        sel_res.addr = req_addr;
        if (int'(req_port) < NUM_PORTS) sel_res = port_res[req_port];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_addr  <= '0;
            rsp_dest  <= '0;
            rsp_table <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && sel_res.hit;
            rsp_addr  <= sel_res.addr;
            rsp_dest  <= sel_res.dest;
            rsp_table <= sel_res.tbl;
        end
    end
endmodule

// File: rtl/atu_checker.sv
module atu_checker
    import atu_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int PORT_W    = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic [PORT_W-1:0]     req_port,
    input logic [ATU_ADDR_W-1:0] req_addr,
    input logic                  rsp_valid,
    input logic                  rsp_hit,
    input logic [ATU_ADDR_W-1:0] rsp_addr,
    input logic [ATU_DEST_W-1:0] rsp_dest,
    input logic [ATU_TBL_W-1:0]  rsp_table
);
    assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_idle_not_hit_R1: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_hit);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!rsp_valid && !rsp_hit));

    assert_miss_passthru_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |->
            (rsp_addr == $past(req_addr) && rsp_dest == '0 && rsp_table == '0));

    assert_bad_port_miss_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(req_port) >= NUM_PORTS) |=> !rsp_hit);

    assert_offset_lsb_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> rsp_addr[0] == $past(req_addr[0]));
endmodule

bind atu_top atu_checker #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_port (req_port),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .rsp_addr (rsp_addr),
    .rsp_dest (rsp_dest),
    .rsp_table(rsp_table)
);

// File: tb/atu_top_tb.sv
module atu_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_waddr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [2:0]  req_port = '0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [63:0] rsp_addr;
    logic [2:0]  rsp_dest;
    logic [1:0]  rsp_table;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    atu_top u_dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_port(req_port), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
        .rsp_dest(rsp_dest), .rsp_table(rsp_table)
    );

    function automatic logic [7:0] ra(input int p, input int t, input int r, input int h);
        return {3'(p), 2'(t), 2'(r), 1'(h)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr64(input int p, input int t, input int r, input logic [63:0] v);
        wr32(ra(p, t, r, 0), v[31:0]);
        wr32(ra(p, t, r, 1), v[63:32]);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_raddr = a;
        #1;
        chk(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic look(input int p, input logic [63:0] a, input bit eh,
                        input logic [63:0] ea, input int ed, input int et, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_port = 3'(p); req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_hit == eh, {tag, " hit"}, 64'(rsp_hit), 64'(eh));
        chk(rsp_addr == ea, {tag, " addr"}, rsp_addr, ea);
        chk(rsp_dest == 3'(ed) && rsp_table == 2'(et), {tag, " dest/table"},
            64'({rsp_dest, rsp_table}), 64'({3'(ed), 2'(et)}));
    endtask

    task automatic t_reset;
        chk(!rsp_valid && !rsp_hit, "R1 outputs idle", 64'({rsp_valid, rsp_hit}), 64'(0));
        rd_chk(ra(0, 0, 0, 0), 32'h0, "R1 src reads zero");
        rd_chk(ra(5, 3, 1, 1), 32'h0, "R1 trsl reads zero");
        look(0, 64'h1_2000_1234, 0, 64'h1_2000_1234, 0, 0, "R1 no entry enabled");
    endtask

    task automatic t_basic;
        wr64(0, 0, 1, 64'h0000_0000_8000_0000);
        wr32(ra(0, 0, 2, 0), 32'h4);
        wr64(0, 0, 0, 64'h0000_0001_2000_001F);
        rd_chk(ra(0, 0, 0, 0), 32'h2000_001F, "R2 src low readback");
        rd_chk(ra(0, 0, 0, 1), 32'h0000_0001, "R2 src high readback");
        rd_chk(ra(0, 0, 3, 0), 32'h0, "R2 reg3 reads zero");
        look(0, 64'h1_2000_1234, 1, 64'h0_8000_1234, 4, 0, "R4 R5 basic hit");
        look(0, 64'h1_2001_0000, 0, 64'h1_2001_0000, 0, 0, "R4 just past window");
        look(0, 64'h1_2000_FFFF, 1, 64'h0_8000_FFFF, 4, 0, "R4 last byte of window");
    endtask

    task automatic t_half;
        wr32(ra(0, 0, 1, 0), 32'h9000_0000);
        rd_chk(ra(0, 0, 1, 0), 32'h8000_0000, "R3 low half not yet live");
        look(0, 64'h1_2000_1234, 1, 64'h0_8000_1234, 4, 0, "R3 lookup uses old base");
        wr32(ra(0, 0, 1, 1), 32'h0000_0002);
        rd_chk(ra(0, 0, 1, 0), 32'h9000_0000, "R3 low half live after commit");
        look(0, 64'h1_2000_1234, 1, 64'h2_9000_1234, 4, 0, "R3 lookup uses new base");
    endtask

    task automatic t_transparent;
        wr32(ra(3, 0, 2, 0), 32'h0);
        wr64(3, 0, 0, 64'h7F);
        look(3, 64'hDEAD_BEEF_0000_1111, 1, 64'hDEAD_BEEF_0000_1111, 0, 0, "R6 pass-through");
        look(3, 64'h0, 1, 64'h0, 0, 0, "R6 zero address");
    endtask

    task automatic t_priority;
        wr64(1, 2, 1, 64'h10_0000_0000);
        wr32(ra(1, 2, 2, 0), 32'h5);
        wr64(1, 2, 0, 64'h4000_0027);
        wr64(1, 1, 1, 64'h20_0000_0000);
        wr32(ra(1, 1, 2, 0), 32'h6);
        wr64(1, 1, 0, 64'h4000_3017);
        look(1, 64'h4000_3ABC, 1, 64'h20_0000_0ABC, 6, 1, "R8 lower table wins");
        look(1, 64'h4000_5ABC, 1, 64'h10_0000_5ABC, 5, 2, "R8 only wider entry hits");
    endtask

    task automatic t_isolation;
        look(2, 64'h1_2000_1234, 0, 64'h1_2000_1234, 0, 0, "R9 other port entry");
        look(6, 64'h4000_3ABC, 0, 64'h4000_3ABC, 0, 0, "R9 port code 6");
        rd_chk(ra(7, 0, 0, 0), 32'h0, "R2 port 7 reads zero");
        wr64(4, 0, 0, 64'h5000_001E);
        look(4, 64'h5000_0010, 0, 64'h5000_0010, 0, 0, "R9 disabled entry");
    endtask

    task automatic t_same_cycle;
        wr32(ra(1, 1, 0, 0), 32'h0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = ra(1, 1, 0, 1); cfg_wdata = 32'h0;
        req_valid = 1'b1; req_port = 3'd1; req_addr = 64'h4000_3ABC;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        chk(rsp_hit && rsp_table == 2'd1 && rsp_addr == 64'h20_0000_0ABC,
            "R11 same-cycle lookup sees old entry", rsp_addr, 64'h20_0000_0ABC);
        look(1, 64'h4000_3ABC, 1, 64'h10_0000_3ABC, 5, 2, "R10 R11 after commit");
    endtask

    task automatic t_disable;
        wr64(0, 0, 0, 64'h0);
        rd_chk(ra(0, 0, 0, 0), 32'h0, "R10 src reads zero");
        look(0, 64'h1_2000_1234, 0, 64'h1_2000_1234, 0, 0, "R10 entry off");
    endtask

    task automatic t_dest;
        wr32(ra(2, 3, 2, 0), 32'hFFFF_FFFA);
        rd_chk(ra(2, 3, 2, 0), 32'h2, "R7 dest code 2 kept, upper zero");
        rd_chk(ra(2, 3, 2, 1), 32'h0, "R7 dest high reads zero");
        wr64(2, 3, 1, 64'hABCD_0000_0000_0000);
        wr64(2, 3, 0, 64'h7000_0017);
        look(2, 64'h7000_0ABC, 1, 64'hABCD_0000_0000_0ABC, 2, 3, "R7 dest 2 on hit");
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_half();
        t_transparent();
        t_priority();
        t_isolation();
        t_same_cycle();
        t_disable();
        t_dest();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule